// File: doc/BRIEF.md
# Network Interrupt Aggregator

This block gathers interrupt requests from the network ports of several module slots and folds them into one interrupt line for the processor. Each pending request is held as a cleared bit in one of two 16-bit status words, so an idle word reads all-ones. Each slot is assigned a status word and a starting bit. A request from a given port of that slot lands at that starting bit plus the port number.

Requests arrive on two sideband strobe channels. One raises a request and one withdraws it, and each carries a slot number and a port number. Software reads the two status words through a small register port. The same register window holds a read/write mask word that software may use freely. The mask has no bearing on the interrupt line.

Top module: `nirq_aggregator`

## Requirements
- R1: After reset both status words read 0xFFFF, the mask word reads 0x0000 and `irq` is low.
- R2: A raise strobe clears one status bit on the next clock edge. The bit is chosen by slot: slot 0 uses status word 0 from bit 0, slot 1 uses status word 1 from bit 0, and slot 2 uses status word 1 from bit 4. The cleared bit is the starting bit plus the port number.
- R3: A withdraw strobe sets the addressed bit back to 1 on the next clock edge, using the same slot mapping as R2.
- R4: When a raise and a withdraw hit the same bit in the same cycle, the raise wins and the bit ends up 0.
- R5: `irq` is a register. It goes high one clock after either status word first differs from 0xFFFF, and goes low one clock after both words are back to 0xFFFF.
- R6: A read of offset 0x26 returns status word 0 and a read of offset 0x28 returns status word 1. A read strobe produces `rdata` and a high `rd_valid` on the following cycle. `rd_valid` is low in every other cycle.
- R7: Writes to offsets 0x26 and 0x28 leave both status words and `irq` unchanged.
- R8: A write to offset 0x30 stores a 16-bit mask word that later reads return unchanged. The mask word never changes `irq`.
- R9: A read of any offset other than 0x26, 0x28 or 0x30 returns 0x0000.
- R10: A strobe with slot number 3, or one whose starting bit plus port reaches 16 or more, changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Raise-request strobe |
| set_slot | input | 2 | Slot of the raise request |
| set_port | input | 4 | Port of the raise request |
| clr_vld | input | 1 | Withdraw-request strobe |
| clr_slot | input | 2 | Slot of the withdraw request |
| clr_port | input | 4 | Port of the withdraw request |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| rd_valid | output | 1 | `rdata` holds a read result |
| irq | output | 1 | Combined network interrupt, high when anything is pending |

## Verification
The bench builds the block with its default widths: 2-bit slot, 4-bit port, 8-bit offset and 16-bit status words. With a 4-bit port, slot 2 can place its starting bit plus port past bit 15, so the discard of out-of-range positions can be reached. A 2-bit slot can carry the unused slot value 3, so the ignored-slot case can also be driven. The bench runs every slot mapping, a raise and withdraw on the same bit in the same cycle, the one-cycle lag of `irq` in both directions, writes aimed at the read-only words, and reads of the mask and of unmapped offsets.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    // Number of module slots that feed the aggregator.
    localparam int NUM_SLOTS = 3;
    // Number of status words.
    localparam int NUM_WORDS = 2;

    // Status word that a slot reports into.
    function automatic int slot_word(input int slot);
        return (slot == 0) ? 0 : 1;
    endfunction

    // First bit that a slot's port 0 occupies within its status word.
    function automatic int slot_base(input int slot);
        return (slot == 2) ? 4 : 0;
    endfunction

endpackage

// File: rtl/nirq_decode.sv
module nirq_decode
    import nirq_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int PORT_W = 4,
    parameter int WORD_W = 16
) (
    input  logic                                vld_i,
    input  logic [SLOT_W-1:0]                   slot_i,
    input  logic [PORT_W-1:0]                   port_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    hit_o
);

    int  word_idx;
    int  bit_pos;
    logic in_range;

    always_comb begin
        word_idx = slot_word(int'(slot_i));
        bit_pos  = slot_base(int'(slot_i)) + int'(port_i);
        in_range = vld_i && (int'(slot_i) < NUM_SLOTS) && (bit_pos < WORD_W);
        for (int w = 0; w < NUM_WORDS; w++) begin
            for (int b = 0; b < WORD_W; b++) begin
                hit_o[w][b] = in_range && (w == word_idx) && (b == bit_pos);
            end
        end
    end

endmodule

// File: rtl/nirq_status.sv
module nirq_status
    import nirq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] set_hit_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] clr_hit_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] stat_o,
    output logic                             irq_o
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] stat;
        logic                             irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Withdraw sets bits high; a raise then pulls low, so raise wins.
        st_d.stat = (st_q.stat | clr_hit_i) & ~set_hit_i;
        st_d.irq  = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (st_q.stat[w] != {WORD_W{1'b1}}) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat <= '1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;

    p_raise_then_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_hit_i) |=> ##1 irq_o);

    p_raise_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_hit_i) |=> ((st_q.stat & $past(set_hit_i)) == '0));

    p_withdraw_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_hit_i) && (set_hit_i == '0)) |=>
            ((st_q.stat & $past(clr_hit_i)) == $past(clr_hit_i)));

    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_hit_i == '0) && (clr_hit_i == '0)) |=> $stable(st_q.stat));

endmodule

// File: rtl/nirq_regif.sv
module nirq_regif
    import nirq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              WORD_W    = 16,
    parameter logic [ADDR_W-1:0] OFS_STAT0 = 8'h26,
    parameter logic [ADDR_W-1:0] OFS_STAT1 = 8'h28,
    parameter logic [ADDR_W-1:0] OFS_MASK  = 8'h30
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en_i,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [WORD_W-1:0]                wdata_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] stat_i,
    output logic [WORD_W-1:0]                rdata_o,
    output logic                             rd_valid_o
);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] rdata;
        logic              rd_valid;
    } state_t;

    state_t st_d, st_q;
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        if (addr_i == OFS_STAT0)      sel_word = stat_i[0];
        else if (addr_i == OFS_STAT1) sel_word = stat_i[1];
        else if (addr_i == OFS_MASK)  sel_word = st_q.mask;
        else                          sel_word = '0;
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en_i;
        if (rd_en_i) st_d.rdata = sel_word;
        if (wr_en_i && (addr_i == OFS_MASK)) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign rd_valid_o = st_q.rd_valid;

    p_read_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    p_mask_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == OFS_MASK)) |=> (st_q.mask == $past(wdata_i)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i != OFS_STAT0) && (addr_i != OFS_STAT1) &&
         (addr_i != OFS_MASK)) |=> (rdata_o == '0));

endmodule

// File: rtl/nirq_aggregator.sv
module nirq_aggregator
    import nirq_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int PORT_W = 4,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_vld,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid,
    output logic              irq
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] set_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0] clr_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0] stat;

    nirq_decode #(.SLOT_W(SLOT_W), .PORT_W(PORT_W), .WORD_W(WORD_W)) u_dec_set (
        .vld_i (set_vld),
        .slot_i(set_slot),
        .port_i(set_port),
        .hit_o (set_hit)
    );

    nirq_decode #(.SLOT_W(SLOT_W), .PORT_W(PORT_W), .WORD_W(WORD_W)) u_dec_clr (
        .vld_i (clr_vld),
        .slot_i(clr_slot),
        .port_i(clr_port),
        .hit_o (clr_hit)
    );

    nirq_status #(.WORD_W(WORD_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hit_i(set_hit),
        .clr_hit_i(clr_hit),
        .stat_o   (stat),
        .irq_o    (irq)
    );

    nirq_regif #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .stat_i    (stat),
        .rdata_o   (rdata),
        .rd_valid_o(rd_valid)
    );

    p_bad_slot_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && (int'(set_slot) >= NUM_SLOTS)) |-> (set_hit == '0));

    p_irq_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat) == '1 && stat == '1) |=> !irq);

endmodule

// File: tb/sim_nirq_aggregator.sv
module sim_nirq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_vld = 1'b0;
    logic [1:0]  set_slot = '0;
    logic [3:0]  set_port = '0;
    logic        clr_vld = 1'b0;
    logic [1:0]  clr_slot = '0;
    logic [3:0]  clr_port = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_valid;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nirq_aggregator u0 (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
        .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All drives happen just after a falling edge; results sampled there too.
    task automatic raise(input int s, input int p);
        set_vld = 1; set_slot = 2'(s); set_port = 4'(p);
        @(negedge clk);
        set_vld = 0;
    endtask

    task automatic withdraw(input int s, input int p);
        clr_vld = 1; clr_slot = 2'(s); clr_port = 4'(p);
        @(negedge clk);
        clr_vld = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v, output logic vl);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rdata; vl = rd_valid;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        wr_en = 1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v; logic vl;
        chk("R1 irq", 16'(irq), 16'h0);
        rd(8'h26, v, vl); chk("R1 word0", v, 16'hFFFF);
        rd(8'h28, v, vl); chk("R1 word1", v, 16'hFFFF);
        rd(8'h30, v, vl); chk("R1 mask", v, 16'h0000);
    endtask

    task automatic t_mapping();
        logic [15:0] v; logic vl;
        raise(0, 3);
        chk("R5 irq lag", 16'(irq), 16'h0);
        @(negedge clk);
        chk("R5 irq up", 16'(irq), 16'h1);
        raise(1, 2);
        raise(2, 1);
        rd(8'h26, v, vl); chk("R2 slot0", v, 16'hFFF7);
        chk("R6 rd_valid", 16'(vl), 16'h1);
        chk("R6 idle valid", 16'(rd_valid), 16'h1);
        @(negedge clk);
        chk("R6 valid drops", 16'(rd_valid), 16'h0);
        rd(8'h28, v, vl); chk("R2 slot1+slot2", v, 16'hFFDB);
        withdraw(0, 3);
        withdraw(1, 2);
        withdraw(2, 1);
        rd(8'h26, v, vl); chk("R3 word0", v, 16'hFFFF);
        rd(8'h28, v, vl); chk("R3 word1", v, 16'hFFFF);
        chk("R5 irq down", 16'(irq), 16'h0);
    endtask

    task automatic t_irq_fall_lag();
        raise(1, 0);
        @(negedge clk);
        chk("R5 irq up2", 16'(irq), 16'h1);
        withdraw(1, 0);
        chk("R5 fall lag", 16'(irq), 16'h1);
        @(negedge clk);
        chk("R5 fall", 16'(irq), 16'h0);
    endtask

    task automatic t_collision();
        logic [15:0] v; logic vl;
        set_vld = 1; set_slot = 0; set_port = 5;
        clr_vld = 1; clr_slot = 0; clr_port = 5;
        @(negedge clk);
        set_vld = 0; clr_vld = 0;
        rd(8'h26, v, vl); chk("R4 raise wins", v, 16'hFFDF);
        withdraw(0, 5);
        rd(8'h26, v, vl); chk("R4 cleanup", v, 16'hFFFF);
    endtask

    task automatic t_write_ignored();
        logic [15:0] v; logic vl;
        wr(8'h26, 16'h0000);
        wr(8'h28, 16'h1234);
        @(negedge clk);
        chk("R7 irq", 16'(irq), 16'h0);
        rd(8'h26, v, vl); chk("R7 word0", v, 16'hFFFF);
        rd(8'h28, v, vl); chk("R7 word1", v, 16'hFFFF);
    endtask

    task automatic t_mask();
        logic [15:0] v; logic vl;
        wr(8'h30, 16'hA5C3);
        rd(8'h30, v, vl); chk("R8 readback", v, 16'hA5C3);
        wr(8'h30, 16'hFFFF);
        @(negedge clk);
        chk("R8 mask no irq", 16'(irq), 16'h0);
        wr(8'h30, 16'h0000);
        raise(0, 0);
        @(negedge clk);
        chk("R8 mask no block", 16'(irq), 16'h1);
        rd(8'h30, v, vl); chk("R8 readback2", v, 16'h0000);
        withdraw(0, 0);
        @(negedge clk);
    endtask

    task automatic t_unmapped();
        logic [15:0] v; logic vl;
        raise(0, 1);
        rd(8'h2A, v, vl); chk("R9 0x2A", v, 16'h0000);
        rd(8'h00, v, vl); chk("R9 0x00", v, 16'h0000);
        rd(8'h27, v, vl); chk("R9 0x27", v, 16'h0000);
        withdraw(0, 1);
        @(negedge clk);
    endtask

    task automatic t_bad_slot();
        logic [15:0] v; logic vl;
        raise(3, 0);
        raise(2, 12);
        @(negedge clk);
        chk("R10 irq", 16'(irq), 16'h0);
        rd(8'h26, v, vl); chk("R10 word0", v, 16'hFFFF);
        rd(8'h28, v, vl); chk("R10 word1", v, 16'hFFFF);
        raise(2, 11);
        rd(8'h28, v, vl); chk("R10 top bit ok", v, 16'h7FFF);
        withdraw(2, 11);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_irq_fall_lag();
        t_collision();
        t_write_ignored();
        t_mask();
        t_unmapped();
        t_bad_slot();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule